// File: doc/BRIEF.md
# Parallel Disk Register Port

This block is the device-side register port of a parallel disk attachment. The host reaches it through two active-low chip selects, a 3-bit register address, active-low read and write strobes and a 16-bit data bus. One chip select opens the command block of eight registers. The other opens the control block. Some addresses name one register when read and a different register when written. The block keeps the task-file parameter registers and an interrupt flag, and presents the parameters to the device core. The core sets the interrupt flag, loads the status and error values, and exchanges data words with the host through the data port.

The host strobes are asynchronous. They pass through a synchroniser, together with the address, chip selects and write data, so that all of these arrive aligned in the core clock domain. A small bus state machine follows the synchronised strobes. Its states are ST_IDLE (no strobe), ST_WRITE (write strobe low; address and data are captured every cycle), ST_WCOMMIT (one cycle after the write strobe rises; the captured write takes effect), ST_READ (read strobe low; the selection is captured) and ST_RDONE (one cycle after the read strobe rises; the side effects of the read take place). Its transitions are: ST_IDLE to ST_WRITE when the write strobe is seen low, and otherwise to ST_READ when the read strobe is seen low. ST_WRITE moves to ST_WCOMMIT when the write strobe is seen high. ST_READ moves to ST_RDONE when the read strobe is seen high. ST_WCOMMIT and ST_RDONE always return to ST_IDLE.

Read data does not wait for the synchroniser: the output enable and the read multiplexer follow the raw strobe, chip selects and address. A pad ring turns `host_data_o`/`host_data_oe` and `host_irq_o`/`host_irq_oe` into tri-state drivers.

Top module: `disk_reg_port`

## Requirements
- R1: After reset every stored register (features, sector count, sector number, cylinder low, cylinder high, drive/head, status, error, interrupt mask) is zero and the interrupt flag is clear. No command pulse is given. The data bus is not driven.
- R2: With only the command chip select active, addresses 2 to 6 are read/write byte registers: sector count, sector number, cylinder low, cylinder high and drive/head. A read returns the stored byte on data bits 7:0, with bits 15:8 zero. `task_params` holds features in [7:0], sector count in [15:8], sector number in [23:16], cylinder low in [31:24], cylinder high in [39:32] and drive/head in [47:40].
- R3: Command-block address 1 reads the core-loaded error byte. A write to it loads the features byte, which shows in `task_params[7:0]` and never in the read value.
- R4: Command-block address 7 reads the core-loaded status byte. A write to it gives `cmd_valid` high for exactly one clock with the written byte on `cmd_byte`, and leaves the status byte unchanged.
- R5: With only the control chip select active, address 6 reads the status byte without side effects, and a write to it stores bit 1 as the interrupt mask. Address 7 reads the drive-address byte {2'b11, ~drive/head[3:0], ~(selected && dev_id==1), ~(selected && dev_id==0)}. Writes to it are ignored. Control addresses 0 to 5, and any access with both chip selects active, neither drive the bus nor change state.
- R6: Command-block address 0 is the 16-bit data port. A host write gives one `core_wr_push` pulse carrying all 16 bits. A host read presents `core_rd_word` on all 16 bits and gives one `core_rd_pop` pulse after the strobe ends.
- R7: `host_wide` is high exactly when only the command chip select is active and the address is 0, whatever the strobes are doing.
- R8: `host_data_oe` is high only while the read strobe is low and a valid register is selected.
- R9: The drive is selected when drive/head bit 4 equals `dev_id`. `host_irq_oe` is high only when the drive is selected and the interrupt mask is 0. `host_irq_o` shows the interrupt flag. The flag becomes set only in the clock after a `core_irq_set` request.
- R10: The interrupt flag is cleared when a host read of command-block address 7 ends, and when a host write to that address commits. A read of control address 6 leaves it set.
- R11: If `core_irq_set` coincides with a clearing access, the flag ends up set.
- R12: A host write takes effect only after the write strobe rises. While the strobe is still low, the target register keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_id | input | 1 | Strap: this device's number (0 or 1) |
| host_cs_cmd_n | input | 1 | Active-low command-block chip select |
| host_cs_ctl_n | input | 1 | Active-low control-block chip select |
| host_addr | input | 3 | Register address |
| host_wr_n | input | 1 | Active-low write strobe |
| host_rd_n | input | 1 | Active-low read strobe |
| host_data_i | input | 16 | Data from the host bus |
| host_data_o | output | 16 | Data toward the host bus |
| host_data_oe | output | 1 | Output enable for the data bus |
| host_irq_o | output | 1 | Interrupt request level |
| host_irq_oe | output | 1 | Output enable for the interrupt line |
| host_wide | output | 1 | 16-bit data register addressed |
| core_irq_set | input | 1 | Core request to set the interrupt flag |
| core_status_we | input | 1 | Load the status byte |
| core_status | input | 8 | New status byte |
| core_error_we | input | 1 | Load the error byte |
| core_error | input | 8 | New error byte |
| core_rd_word | input | 16 | Word the host reads from the data port |
| core_rd_pop | output | 1 | Host finished reading a data word |
| core_wr_word | output | 16 | Word the host wrote to the data port |
| core_wr_push | output | 1 | Host wrote a data word |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Command byte |
| task_params | output | 48 | Task-file parameter registers |

## Verification
The bench goes after the aliased addresses. A design that decodes address 1 or 7 the same way for reads and writes would return the features byte where the error byte belongs, or would lose the status byte to a command write. It sweeps every address under every chip-select combination for the wide indication and the bus enable. It also sweeps device number, drive-select bit and mask for the interrupt enable. Either sweep exposes an off-by-one decode or an inverted select. The interrupt clearing rules are tested as follows: a read of the alternate status must keep the flag, and a request that coincides with a status read must win. A design that clears on both status addresses, or gives the clear priority, leaves the interrupt line low. A write held low for several cycles must not reach the register early, which catches a commit on the falling edge.

// File: rtl/drp_pkg.sv
package drp_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] CB_DATA    = 3'd0;
    localparam logic [REG_AW-1:0] CB_ERRFEAT = 3'd1;
    localparam logic [REG_AW-1:0] CB_SECCNT  = 3'd2;
    localparam logic [REG_AW-1:0] CB_DRVHD   = 3'd6;
    localparam logic [REG_AW-1:0] CB_STATCMD = 3'd7;
    localparam logic [REG_AW-1:0] KB_ALTCTL  = 3'd6;
    localparam logic [REG_AW-1:0] KB_DRVADDR = 3'd7;

    localparam int DRVSEL_BIT  = 4;
    localparam int IRQMASK_BIT = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WCOMMIT,
        ST_READ,
        ST_RDONE
    } bus_state_t;

    typedef struct packed {
        logic                 cmd;
        logic                 ctl;
        logic [REG_AW-1:0]    addr;
    } reg_sel_t;
endpackage

// File: rtl/drp_sync.sv
module drp_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/drp_bus_fsm.sv
module drp_bus_fsm
    import drp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_s_n,
    input  logic rd_s_n,
    output logic capture_wr,
    output logic commit,
    output logic capture_rd,
    output logic rd_done
);
    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!wr_s_n)      state_d = ST_WRITE;
                else if (!rd_s_n) state_d = ST_READ;
            end
            ST_WRITE:   if (wr_s_n) state_d = ST_WCOMMIT;
            ST_WCOMMIT: state_d = ST_IDLE;
            ST_READ:    if (rd_s_n) state_d = ST_RDONE;
            ST_RDONE:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_wr = 1'b0;
        commit     = 1'b0;
        capture_rd = 1'b0;
        rd_done    = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_WRITE:   capture_wr = !wr_s_n;
            ST_WCOMMIT: commit     = 1'b1;
            ST_READ:    capture_rd = !rd_s_n;
            ST_RDONE:   rd_done    = 1'b1;
            default:    ;
        endcase
    end

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);                                       // R12
    AST_COMMIT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(wr_s_n));                                 // R12
    AST_RDDONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);                                     // R6
endmodule

// File: rtl/drp_regfile.sv
module drp_regfile
    import drp_pkg::*;
#(
    parameter int DW = 16,
    parameter int RW = 8,
    localparam int NTF = int'(CB_DRVHD) - int'(CB_SECCNT) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  reg_sel_t          wr_sel,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_done,
    input  reg_sel_t          rd_sel,
    input  logic              core_irq_set,
    input  logic              core_status_we,
    input  logic [RW-1:0]     core_status,
    input  logic              core_error_we,
    input  logic [RW-1:0]     core_error,
    output logic [RW-1:0]     features_q,
    output logic [NTF*RW-1:0] tf_q,
    output logic [RW-1:0]     status_q,
    output logic [RW-1:0]     error_q,
    output logic              irq_mask_q,
    output logic              irq_flag_q,
    output logic              cmd_valid_q,
    output logic [RW-1:0]     cmd_byte_q,
    output logic              push_q,
    output logic [DW-1:0]     push_word_q,
    output logic              pop_q
);
    logic          cb_wr, kb_wr, cb_rd, kb_rd;
    logic          cmd_wr, stat_rd, alt_rd, irq_clr;
    logic [RW-1:0] wbyte;

    assign cb_wr   = wr_commit && wr_sel.cmd && !wr_sel.ctl;
    assign kb_wr   = wr_commit && wr_sel.ctl && !wr_sel.cmd;
    assign cb_rd   = rd_done && rd_sel.cmd && !rd_sel.ctl;
    assign kb_rd   = rd_done && rd_sel.ctl && !rd_sel.cmd;
    assign wbyte   = wr_data[RW-1:0];
    assign cmd_wr  = cb_wr && (wr_sel.addr == CB_STATCMD);
    assign stat_rd = cb_rd && (rd_sel.addr == CB_STATCMD);
    assign alt_rd  = kb_rd && (rd_sel.addr == KB_ALTCTL);
    assign irq_clr = cmd_wr || stat_rd;

    generate
        for (genvar a = 0; a < NTF; a++) begin : g_tf
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    tf_q[a*RW +: RW] <= '0;
                else if (cb_wr && wr_sel.addr == REG_AW'(int'(CB_SECCNT) + a))
                    tf_q[a*RW +: RW] <= wbyte;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            features_q  <= '0;
            status_q    <= '0;
            error_q     <= '0;
            irq_mask_q  <= 1'b0;
            irq_flag_q  <= 1'b0;
            cmd_valid_q <= 1'b0;
            cmd_byte_q  <= '0;
            push_q      <= 1'b0;
            push_word_q <= '0;
            pop_q       <= 1'b0;
        end else begin
            cmd_valid_q <= cmd_wr;
            push_q      <= cb_wr && (wr_sel.addr == CB_DATA);
            pop_q       <= cb_rd && (rd_sel.addr == CB_DATA);
            if (cmd_wr) cmd_byte_q <= wbyte;
            if (cb_wr && wr_sel.addr == CB_DATA) push_word_q <= wr_data;
            if (cb_wr && wr_sel.addr == CB_ERRFEAT) features_q <= wbyte;
            if (kb_wr && wr_sel.addr == KB_ALTCTL) irq_mask_q <= wbyte[IRQMASK_BIT];
            if (core_status_we) status_q <= core_status;
            if (core_error_we)  error_q  <= core_error;
            if (core_irq_set)   irq_flag_q <= 1'b1;
            else if (irq_clr)   irq_flag_q <= 1'b0;
        end
    end

    AST_IRQ_ONLY_BY_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_flag_q && !core_irq_set) |=> !irq_flag_q);           // R9
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !core_irq_set) |=> !irq_flag_q);               // R10
    AST_ALT_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_rd && irq_flag_q) |=> irq_flag_q);                    // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq_set |=> irq_flag_q);                              // R11
    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_q |=> !cmd_valid_q);                             // R4
    AST_STATUS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !core_status_we) |=> $stable(status_q));        // R4
endmodule

// File: rtl/disk_reg_port.sv
module disk_reg_port
    import drp_pkg::*;
#(
    parameter int DW          = 16,
    parameter int RW          = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NTF        = int'(CB_DRVHD) - int'(CB_SECCNT) + 1,
    localparam int SYNC_W     = 4 + REG_AW + DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_id,
    input  logic              host_cs_cmd_n,
    input  logic              host_cs_ctl_n,
    input  logic [REG_AW-1:0] host_addr,
    input  logic              host_wr_n,
    input  logic              host_rd_n,
    input  logic [DW-1:0]     host_data_i,
    output logic [DW-1:0]     host_data_o,
    output logic              host_data_oe,
    output logic              host_irq_o,
    output logic              host_irq_oe,
    output logic              host_wide,
    input  logic              core_irq_set,
    input  logic              core_status_we,
    input  logic [RW-1:0]     core_status,
    input  logic              core_error_we,
    input  logic [RW-1:0]     core_error,
    input  logic [DW-1:0]     core_rd_word,
    output logic              core_rd_pop,
    output logic [DW-1:0]     core_wr_word,
    output logic              core_wr_push,
    output logic              cmd_valid,
    output logic [RW-1:0]     cmd_byte,
    output logic [(NTF+1)*RW-1:0] task_params
);
    localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1111, {(REG_AW + DW){1'b0}}};

    logic [SYNC_W-1:0] raw_bus, syn_bus;
    logic              wr_s_n, rd_s_n, cs_cmd_s_n, cs_ctl_s_n;
    logic [REG_AW-1:0] addr_s;
    logic [DW-1:0]     data_s;
    logic              capture_wr, commit, capture_rd, rd_done;
    reg_sel_t          wr_sel_q, rd_sel_q, live_sel;
    logic [DW-1:0]     wr_data_q;

    logic [RW-1:0]     features_q, status_q, error_q;
    logic [NTF*RW-1:0] tf_q;
    logic              irq_mask_q, irq_flag_q;
    logic [RW-1:0]     drvhd, drv_addr;
    logic              drv_sel, rd_valid;

    assign raw_bus = {host_wr_n, host_rd_n, host_cs_cmd_n, host_cs_ctl_n, host_addr, host_data_i};
    assign {wr_s_n, rd_s_n, cs_cmd_s_n, cs_ctl_s_n, addr_s, data_s} = syn_bus;

    drp_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus)
    );

    drp_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_s_n(wr_s_n), .rd_s_n(rd_s_n),
        .capture_wr(capture_wr), .commit(commit),
        .capture_rd(capture_rd), .rd_done(rd_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_sel_q  <= '0;
            rd_sel_q  <= '0;
            wr_data_q <= '0;
        end else begin
            if (capture_wr) begin
                wr_sel_q  <= '{cmd: !cs_cmd_s_n, ctl: !cs_ctl_s_n, addr: addr_s};
                wr_data_q <= data_s;
            end
            if (capture_rd)
                rd_sel_q <= '{cmd: !cs_cmd_s_n, ctl: !cs_ctl_s_n, addr: addr_s};
        end
    end

    drp_regfile #(.DW(DW), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_commit(commit), .wr_sel(wr_sel_q), .wr_data(wr_data_q),
        .rd_done(rd_done), .rd_sel(rd_sel_q),
        .core_irq_set(core_irq_set),
        .core_status_we(core_status_we), .core_status(core_status),
        .core_error_we(core_error_we), .core_error(core_error),
        .features_q(features_q), .tf_q(tf_q),
        .status_q(status_q), .error_q(error_q),
        .irq_mask_q(irq_mask_q), .irq_flag_q(irq_flag_q),
        .cmd_valid_q(cmd_valid), .cmd_byte_q(cmd_byte),
        .push_q(core_wr_push), .push_word_q(core_wr_word), .pop_q(core_rd_pop)
    );

    assign drvhd    = tf_q[(NTF-1)*RW +: RW];
    assign drv_sel  = (drvhd[DRVSEL_BIT] == dev_id);
    assign drv_addr = {2'b11, ~drvhd[3:0], ~(drv_sel && dev_id), ~(drv_sel && !dev_id)};
    assign live_sel = '{cmd: !host_cs_cmd_n, ctl: !host_cs_ctl_n, addr: host_addr};

    always_comb begin
        rd_valid    = 1'b0;
        host_data_o = '0;
        if (live_sel.cmd && !live_sel.ctl) begin
            rd_valid = 1'b1;
            if (live_sel.addr == CB_DATA)
                host_data_o = core_rd_word;
            else if (live_sel.addr == CB_ERRFEAT)
                host_data_o = DW'(error_q);
            else if (live_sel.addr == CB_STATCMD)
                host_data_o = DW'(status_q);
            else
                host_data_o = DW'(tf_q[(int'(live_sel.addr) - int'(CB_SECCNT))*RW +: RW]);
        end else if (live_sel.ctl && !live_sel.cmd) begin
            if (live_sel.addr == KB_ALTCTL) begin
                rd_valid    = 1'b1;
                host_data_o = DW'(status_q);
            end else if (live_sel.addr == KB_DRVADDR) begin
                rd_valid    = 1'b1;
                host_data_o = DW'(drv_addr);
            end
        end
    end

    assign host_data_oe = !host_rd_n && rd_valid;
    assign host_wide    = live_sel.cmd && !live_sel.ctl && (live_sel.addr == CB_DATA);
    assign host_irq_o   = irq_flag_q;
    assign host_irq_oe  = drv_sel && !irq_mask_q;
    assign task_params  = {tf_q, features_q};

    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr_push |=> !core_wr_push);                           // R6
    AST_POP_NOT_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        core_rd_pop |-> !core_wr_push);                            // R6
    AST_CMD_NOT_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !core_wr_push);                              // R4
endmodule

// File: tb/sim_disk_reg_port.sv
`timescale 1ns/1ps
module sim_disk_reg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_id = 1'b0;
    logic        cs_cmd_n = 1'b1, cs_ctl_n = 1'b1;
    logic [2:0]  addr = '0;
    logic        wr_n = 1'b1, rd_n = 1'b1;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        doe, irq_o, irq_oe, wide;
    logic        irq_set = 1'b0, st_we = 1'b0, er_we = 1'b0;
    logic [7:0]  st_val = '0, er_val = '0;
    logic [15:0] rd_word = '0;
    logic        pop, push, cmdv;
    logic [15:0] push_word;
    logic [7:0]  cmdb;
    logic [47:0] params;

    int checks = 0;
    int fails  = 0;
    int n_cmd = 0, n_push = 0, n_pop = 0;
    logic [7:0] last_cmd = '0;

    always #2.5 clk = ~clk;

    disk_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id),
        .host_cs_cmd_n(cs_cmd_n), .host_cs_ctl_n(cs_ctl_n), .host_addr(addr),
        .host_wr_n(wr_n), .host_rd_n(rd_n), .host_data_i(din),
        .host_data_o(dout), .host_data_oe(doe),
        .host_irq_o(irq_o), .host_irq_oe(irq_oe), .host_wide(wide),
        .core_irq_set(irq_set), .core_status_we(st_we), .core_status(st_val),
        .core_error_we(er_we), .core_error(er_val),
        .core_rd_word(rd_word), .core_rd_pop(pop),
        .core_wr_word(push_word), .core_wr_push(push),
        .cmd_valid(cmdv), .cmd_byte(cmdb), .task_params(params)
    );

    always @(posedge clk) begin
        if (cmdv) begin n_cmd <= n_cmd + 1; last_cmd <= cmdb; end
        if (push) n_push <= n_push + 1;
        if (pop)  n_pop  <= n_pop + 1;
    end

    task automatic chk(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic host_write(input logic c, input logic k, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cs_cmd_n = !c; cs_ctl_n = !k; addr = a; din = d; wr_n = 1'b0;
        repeat (5) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic host_read(input logic c, input logic k, input logic [2:0] a,
                             output logic [15:0] v, output logic oe);
        @(negedge clk);
        cs_cmd_n = !c; cs_ctl_n = !k; addr = a; rd_n = 1'b0;
        repeat (2) @(negedge clk);
        v = dout; oe = doe;
        repeat (3) @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] v;
        logic        oe;
        logic [7:0]  exp_b [2:6];
        logic [47:0] snap;
        int          c0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1", "task_params", params, 48'h0);
        chk("R1", "bus enable", {47'h0, doe}, 48'h0);
        chk("R1", "irq flag", {47'h0, irq_o}, 48'h0);
        chk("R1", "irq enable", {47'h0, irq_oe}, 48'h1);
        chk("R1", "cmd pulses", 48'(n_cmd), 48'h0);
        host_read(1, 0, 3'd7, v, oe);
        chk("R1", "status read", {32'h0, v}, 48'h0);

        // R2 sweep of the plain byte registers
        for (int k = 0; k < 3; k++) begin
            for (int a = 2; a <= 6; a++) begin
                exp_b[a] = 8'((a * 53 + k * 29 + 7) & 8'hFF);
                host_write(1, 0, 3'(a), {8'hEE, exp_b[a]});
            end
            for (int a = 2; a <= 6; a++) begin
                host_read(1, 0, 3'(a), v, oe);
                chk("R2", $sformatf("read addr %0d", a), {32'h0, v}, {40'h0, exp_b[a]});
                chk("R8", "enable on valid read", {47'h0, oe}, 48'h1);
            end
            chk("R2", "task_params", params,
                {exp_b[6], exp_b[5], exp_b[4], exp_b[3], exp_b[2], 8'h00});
        end

        // R12 commit only after strobe release
        snap = params;
        @(negedge clk);
        cs_cmd_n = 1'b0; addr = 3'd2; din = 16'h00A5; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R12", "held while strobe low", {40'h0, params[15:8]}, {40'h0, snap[15:8]});
        wr_n = 1'b1;
        @(negedge clk);
        cs_cmd_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R12", "after release", {40'h0, params[15:8]}, 48'hA5);
        host_write(1, 0, 3'd6, 16'h0000);

        // R3 error/features aliasing
        @(negedge clk); er_val = 8'h5A; er_we = 1'b1;
        @(negedge clk); er_we = 1'b0;
        host_write(1, 0, 3'd1, 16'h00C3);
        host_read(1, 0, 3'd1, v, oe);
        chk("R3", "read returns error", {32'h0, v}, 48'h5A);
        chk("R3", "features stored", {40'h0, params[7:0]}, 48'hC3);

        // R4 status/command aliasing
        @(negedge clk); st_val = 8'h50; st_we = 1'b1;
        @(negedge clk); st_we = 1'b0;
        c0 = n_cmd;
        host_write(1, 0, 3'd7, 16'h00EC);
        chk("R4", "one command pulse", 48'(n_cmd - c0), 48'h1);
        chk("R4", "command byte", {40'h0, last_cmd}, 48'hEC);
        host_read(1, 0, 3'd7, v, oe);
        chk("R4", "status unchanged", {32'h0, v}, 48'h50);

        // R5 control block
        host_read(0, 1, 3'd6, v, oe);
        chk("R5", "alt status", {32'h0, v}, 48'h50);
        host_read(0, 1, 3'd7, v, oe);
        chk("R5", "drive address", {32'h0, v}, 48'hFE);
        for (int a = 0; a < 6; a++) begin
            host_read(0, 1, 3'(a), v, oe);
            chk("R5", $sformatf("ctl addr %0d undriven", a), {47'h0, oe}, 48'h0);
        end
        host_read(1, 1, 3'd7, v, oe);
        chk("R5", "both selects undriven", {47'h0, oe}, 48'h0);
        snap = params; c0 = n_cmd;
        host_write(0, 1, 3'd7, 16'h00FF);
        host_write(1, 1, 3'd7, 16'h0091);
        host_write(1, 1, 3'd3, 16'h0077);
        chk("R5", "ignored writes params", params, snap);
        chk("R5", "ignored writes cmd", 48'(n_cmd - c0), 48'h0);
        chk("R5", "ignored writes irq enable", {47'h0, irq_oe}, 48'h1);

        // R6 data port
        rd_word = 16'hBEEF; c0 = n_pop;
        host_read(1, 0, 3'd0, v, oe);
        chk("R6", "data read word", {32'h0, v}, 48'hBEEF);
        chk("R6", "one pop", 48'(n_pop - c0), 48'h1);
        c0 = n_push; snap = params;
        host_write(1, 0, 3'd0, 16'h1234);
        chk("R6", "one push", 48'(n_push - c0), 48'h1);
        chk("R6", "push word", {32'h0, push_word}, 48'h1234);
        chk("R6", "params untouched", params, snap);

        // R7 / R8 selection sweep
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 8; a++) begin
                @(negedge clk);
                cs_cmd_n = s[0]; cs_ctl_n = s[1]; addr = 3'(a); rd_n = 1'b1;
                #1;
                chk("R7", $sformatf("wide s%0d a%0d", s, a), {47'h0, wide},
                    {47'h0, (s == 2 && a == 0)});
                chk("R8", $sformatf("idle enable s%0d a%0d", s, a), {47'h0, doe}, 48'h0);
            end
        end
        @(negedge clk); cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;

        // R9 interrupt enable sweep
        for (int id = 0; id < 2; id++) begin
            for (int b = 0; b < 2; b++) begin
                for (int m = 0; m < 2; m++) begin
                    dev_id = id[0];
                    host_write(1, 0, 3'd6, {11'h0, b[0], 4'h0});
                    host_write(0, 1, 3'd6, {14'h0, m[0], 1'b0});
                    chk("R9", $sformatf("irq enable id%0d b%0d m%0d", id, b, m),
                        {47'h0, irq_oe}, {47'h0, (id == b) && (m == 0)});
                end
            end
        end
        dev_id = 1'b0;
        host_write(1, 0, 3'd6, 16'h0000);
        host_write(0, 1, 3'd6, 16'h0000);
        chk("R9", "flag idle", {47'h0, irq_o}, 48'h0);
        @(negedge clk); irq_set = 1'b1;
        @(negedge clk); irq_set = 1'b0;
        chk("R9", "flag set by core", {47'h0, irq_o}, 48'h1);

        // R10 clearing rules
        host_read(0, 1, 3'd6, v, oe);
        chk("R10", "alt status keeps flag", {47'h0, irq_o}, 48'h1);
        host_read(1, 0, 3'd7, v, oe);
        chk("R10", "status read clears", {47'h0, irq_o}, 48'h0);
        @(negedge clk); irq_set = 1'b1;
        @(negedge clk); irq_set = 1'b0;
        host_write(1, 0, 3'd7, 16'h0020);
        chk("R10", "command write clears", {47'h0, irq_o}, 48'h0);

        // R11 request coinciding with a clearing read
        @(negedge clk); irq_set = 1'b1;
        host_read(1, 0, 3'd7, v, oe);
        irq_set = 1'b0;
        @(negedge clk);
        chk("R11", "set wins over clear", {47'h0, irq_o}, 48'h1);

        summary();
    end
endmodule